// File: doc/BRIEF.md
# Register Rename Map with Free List and Branch Snapshot

This block performs explicit register renaming for an out-of-order core. Each renamed instruction presents two architected source registers and one architected destination. The block translates the sources through a map table and takes a new physical tag for the destination from a free list. It also reports the physical tag that the destination held until now. That displaced tag travels with the instruction, and it is handed back through the commit port when the instruction retires. At that point no architected register refers to the tag and no in-flight reader can still need it.

A single snapshot slot saves the map table and the free list at a branch. If the branch was mispredicted, a restore puts both back in one cycle. Tags that are released by commits while a snapshot is held are also recorded in the snapshot. A restore therefore never loses a tag that has been released.

Top module: `rename_map`

## Requirements
- R1: After reset, architected register r maps to physical tag r for r in 0..15. Tags 16..47 are free, `ren_ready` is 1 and `ren_pdst` is 16.
- R2: `ren_psrc_a` and `ren_psrc_b` give the current mapping of `ren_src_a` and `ren_src_b`. A source that names the destination of the rename in the same cycle sees the mapping from before that rename.
- R3: `ren_pdst` is the lowest-numbered free tag and `ren_pold` is the current mapping of `ren_dst`. When a rename is accepted (`ren_valid` and `ren_ready`), the destination maps to `ren_pdst` from the next cycle and that tag leaves the free list.
- R4: `ren_ready` is 0 while the free list is empty. A rename offered while `ren_ready` is 0 changes neither the map nor the free list.
- R5: `commit_valid` returns `commit_tag` to the free list from the next cycle. A rename in the same cycle does not see that tag.
- R6: `ckpt_take` saves the map and the free list as they stand after the same cycle's rename. There is one slot, and a later `ckpt_take` overwrites it.
- R7: On `ckpt_restore` the map and the free list equal the saved snapshot from the next cycle. `ren_ready` is 0 during the restore cycle, and a `ckpt_take` in that cycle is ignored.
- R8: A tag committed between a snapshot and its restore is still free after the restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request |
| ren_src_a | input | 4 | Architected source A |
| ren_src_b | input | 4 | Architected source B |
| ren_dst | input | 4 | Architected destination |
| ren_ready | output | 1 | Rename can be accepted |
| ren_psrc_a | output | 6 | Physical tag of source A |
| ren_psrc_b | output | 6 | Physical tag of source B |
| ren_pdst | output | 6 | Newly allocated tag |
| ren_pold | output | 6 | Displaced tag of the destination |
| commit_valid | input | 1 | Release a tag |
| commit_tag | input | 6 | Tag to release |
| ckpt_take | input | 1 | Save map and free list |
| ckpt_restore | input | 1 | Restore map and free list |

## Verification
A commit and a rename can fall in the same cycle, and so can a commit and a restore. The bench first drains the free list completely. It then releases a tag in the same cycle as a rename attempt and expects `ren_ready` to stay 0 until the next cycle. Later it releases a low tag while a snapshot is held and then restores. The next allocation must be that tag, which shows that the commit reached both the live free list and the saved one.

// File: rtl/rename_map.sv
module rename_map #(
  parameter int NARCH = 16,
  parameter int NPHYS = 48,
  localparam int AW = $clog2(NARCH),
  localparam int PW = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic [AW-1:0] ren_src_a,
  input  logic [AW-1:0] ren_src_b,
  input  logic [AW-1:0] ren_dst,
  output logic          ren_ready,
  output logic [PW-1:0] ren_psrc_a,
  output logic [PW-1:0] ren_psrc_b,
  output logic [PW-1:0] ren_pdst,
  output logic [PW-1:0] ren_pold,
  input  logic          commit_valid,
  input  logic [PW-1:0] commit_tag,
  input  logic          ckpt_take,
  input  logic          ckpt_restore
);
  localparam logic [NPHYS-1:0] RST_FREE = {{(NPHYS-NARCH){1'b1}}, {NARCH{1'b0}}};

  logic [PW-1:0]    map_q [NARCH];
  logic [PW-1:0]    map_nxt [NARCH];
  logic [PW-1:0]    snap_map [NARCH];
  logic [NPHYS-1:0] free_q, free_nxt, snap_free, cmask;
  logic [PW-1:0]    alloc;
  logic             fire;

  always_comb begin
    alloc = '0;
    for (int i = NPHYS-1; i >= 0; i--)
      if (free_q[i]) alloc = PW'(i);
  end

  assign ren_ready  = (|free_q) & ~ckpt_restore;
  assign fire       = ren_valid & ren_ready;
  assign ren_psrc_a = map_q[ren_src_a];
  assign ren_psrc_b = map_q[ren_src_b];
  assign ren_pold   = map_q[ren_dst];
  assign ren_pdst   = alloc;
  assign cmask      = commit_valid ? (NPHYS'(1) << commit_tag) : '0;

  always_comb begin
    map_nxt  = map_q;
    free_nxt = free_q;
    if (fire) begin
      map_nxt[ren_dst] = alloc;
      free_nxt[alloc]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NARCH; i++) begin
        map_q[i]    <= PW'(i);
        snap_map[i] <= PW'(i);
      end
      free_q    <= RST_FREE;
      snap_free <= RST_FREE;
    end else if (ckpt_restore) begin
      map_q     <= snap_map;
      free_q    <= snap_free | cmask;
      snap_free <= snap_free | cmask;
    end else begin
      map_q  <= map_nxt;
      free_q <= free_nxt | cmask;
      if (ckpt_take) begin
        snap_map  <= map_nxt;
        snap_free <= free_nxt | cmask;
      end else begin
        snap_free <= snap_free | cmask;
      end
    end
  end
endmodule

// File: rtl/rename_map_chk.sv
module rename_map_chk #(
  parameter int NPHYS = 48,
  parameter int PW = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ren_valid,
  input logic             ren_ready,
  input logic [PW-1:0]    ren_pdst,
  input logic             commit_valid,
  input logic [PW-1:0]    commit_tag,
  input logic             ckpt_restore,
  input logic [NPHYS-1:0] free_q
);
  assert_alloc_is_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_ready) |-> free_q[ren_pdst]);

  assert_alloc_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_ready && !(commit_valid && commit_tag == ren_pdst)) |=> !free_q[$past(ren_pdst)]);

  assert_empty_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (free_q == '0) |-> !ren_ready);

  assert_commit_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> free_q[$past(commit_tag)]);

  assert_restore_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_restore |-> !ren_ready);
endmodule

bind rename_map rename_map_chk #(.NPHYS(NPHYS), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
  .ren_pdst(ren_pdst), .commit_valid(commit_valid), .commit_tag(commit_tag),
  .ckpt_restore(ckpt_restore), .free_q(free_q)
);

// File: tb/sim_rename_map.sv
module sim_rename_map;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rv = 0, cv = 0, ck = 0, rs = 0;
  logic [3:0] rdst = 0, rsa = 0, rsb = 0;
  logic [5:0] ctag = 0;
  logic rdy;
  logic [5:0] psa, psb, pdst, pold;
  int checks = 0, fails = 0;

  logic [5:0]  map_m [16];
  logic [5:0]  snap_map_m [16];
  logic [47:0] free_m, snap_free_m;

  always #2 clk = ~clk;

  rename_map u0 (
    .clk(clk), .rst_n(rst_n), .ren_valid(rv), .ren_src_a(rsa), .ren_src_b(rsb),
    .ren_dst(rdst), .ren_ready(rdy), .ren_psrc_a(psa), .ren_psrc_b(psb),
    .ren_pdst(pdst), .ren_pold(pold), .commit_valid(cv), .commit_tag(ctag),
    .ckpt_take(ck), .ckpt_restore(rs)
  );

  function automatic int lowest(input logic [47:0] f);
    for (int i = 47; i >= 0; i--) if (f[i]) lowest = i;
    if (f == '0) lowest = 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input int d, input int sa, input int sb,
                      input logic c, input int ct, input logic k, input logic r);
    logic er, fire;
    int a;
    @(negedge clk);
    rv = v; rdst = 4'(d); rsa = 4'(sa); rsb = 4'(sb);
    cv = c; ctag = 6'(ct); ck = k; rs = r;
    #1;
    er = (free_m != '0) && !r;
    chk(rdy == er, r ? "R7" : "R4", int'(rdy), int'(er));
    a = lowest(free_m);
    if (v) begin
      chk(psa == map_m[sa], "R2", int'(psa), int'(map_m[sa]));
      chk(psb == map_m[sb], "R2", int'(psb), int'(map_m[sb]));
      chk(pold == map_m[d], "R3", int'(pold), int'(map_m[d]));
      if (er) chk(int'(pdst) == a, "R3", int'(pdst), a);
    end
    fire = v && er;
    @(posedge clk);
    if (r) begin
      map_m = snap_map_m;
      free_m = snap_free_m;
    end else begin
      if (fire) begin
        map_m[d] = 6'(a);
        free_m[a] = 1'b0;
      end
      if (k) begin
        snap_map_m = map_m;
        snap_free_m = free_m;
      end
    end
    if (c) begin
      free_m[ct] = 1'b1;
      snap_free_m[ct] = 1'b1;
    end
  endtask

  task automatic probe(input string req);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      rv = 0; cv = 0; ck = 0; rs = 0; rsa = 4'(i);
      #1;
      chk(psa == map_m[i], req, int'(psa), int'(map_m[i]));
    end
    chk(rdy == (free_m != '0), req, int'(rdy), int'(free_m != '0));
    if (free_m != '0) chk(int'(pdst) == lowest(free_m), req, int'(pdst), lowest(free_m));
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      map_m[i] = 6'(i);
      snap_map_m[i] = 6'(i);
    end
    free_m = {{32{1'b1}}, {16{1'b0}}};
    snap_free_m = free_m;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    probe("R1");
    chk(int'(pdst) == 16, "R1", int'(pdst), 16);
    // R2/R3 sweep: source B names the destination, sees pre-rename tag
    for (int i = 0; i < 32; i++) step(1, i % 16, (i + 3) % 16, i % 16, 0, 0, 0, 0);
    // R4 empty: request ignored
    step(1, 7, 1, 2, 0, 0, 0, 0);
    probe("R4");
    // R5 commit in same cycle as a stalled rename
    step(1, 2, 0, 1, 1, 5, 0, 0);
    step(0, 0, 0, 0, 1, 3, 0, 0);
    chk(free_m[5] && free_m[3], "R5", int'(free_m[5]), 1);
    step(1, 4, 4, 9, 0, 0, 0, 0);
    for (int t = 6; t < 16; t++) step(0, 0, 0, 0, 1, t, 0, 0);
    // R6 checkpoint together with a rename, R8 commit while held
    step(1, 1, 1, 2, 0, 0, 1, 0);
    for (int i = 0; i < 3; i++) step(1, 9 + i, 1, 9 + i, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    step(1, 6, 6, 6, 0, 0, 1, 1);
    probe("R7");
    chk(int'(pdst) == 0, "R8", int'(pdst), 0);
    // R6 overwrite: second snapshot wins
    step(1, 12, 0, 0, 0, 0, 1, 0);
    step(1, 13, 0, 0, 0, 0, 0, 0);
    step(1, 14, 0, 0, 0, 0, 1, 0);
    step(1, 15, 14, 15, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    probe("R6");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule